// File: doc/BRIEF.md
# IDENTIFY Data Capability Parser

This block sits beside a storage host port and digests the 256-word identify block that a drive returns during discovery. The words arrive as a stream, one 16-bit word per accepted beat together with its index (0 to 255, in increasing order). The block keeps only the few dozen words that matter and throws the rest away. When the final word has been accepted, it works out the drive's capabilities in one step: addressing mode, capacity, transfer-mode level, link speeds, sector geometry and world wide name. It also decides whether the drive must be rejected because a link reset would wipe its configuration.

The signature half (the upper 16 bits of the drive signature) is a static input. It tells a packet-command device apart from a conventional disk. Results appear on registered outputs together with a one-cycle completion pulse, and they hold their values until the next complete block has been parsed.

Top module: `identParse`

## Requirements
- R1: `done` pulses high for exactly one cycle, in the cycle after word 255 of an open block is accepted. All result outputs update only in that cycle and hold otherwise. After reset every output is zero.
- R2: `capFlags` bit 0 (LBA) equals word 49 bit 9. Bit 1 (48-bit LBA) is set only when bit 0 is set and bit 10 of word 83 or of word 86 is set.
- R3: With 48-bit LBA, the raw capacity is words 103..100 (word 103 most significant). With plain LBA it is words 61..60 (word 61 most significant).
- R4: Without LBA, the raw capacity is cylinders × heads × sectors. These come from words 1, 3, 6 when word 53 bit 0 is set, and from words 54, 55, 56 otherwise.
- R5: `udmaCount` is 0xFF unless word 49 bit 8 and word 53 bit 2 are both set. In that case it is 0xFF plus the number of right shifts that empty word 88 bits 6:0, modulo 256: the index of the highest set bit, or 0xFF if those bits are all zero.
- R6: The flags power (bit 3), SMART (bit 2) and NOP (bit 4) are set only when word 83 bits 15:14 equal 01. They then equal word 83 bit 3, word 82 bit 0 and word 82 bit 14 respectively.
- R7: Words 80, 76 and 222 read as zero when they equal 0xFFFF. `capFlags` bit 7 (ATA8) is bit 8 of the cleaned word 80.
- R8: When ATA8 is set, cleaned word 222 has bits 15:12 = 0001 and cleaned word 76 is nonzero, `speeds` is word 76 bits 3:1. In that case `reject` is high if bit 6 of (word 78 AND word 79) is clear. Otherwise `speeds` and `reject` are zero.
- R9: For a non-packet device with word 106 bits 15:14 = 01, `logSectSize` is twice the 32-bit value of words 118:117 (word 118 high) when that value is at least 256. `physShift` is word 106 bits 2:0 when word 106 bit 13 is set. In every other case `logSectSize` is 512 and `physShift` is 0.
- R10: `capacity` is the raw capacity shifted right by `physShift`.
- R11: `wwn` is words 108,109,110,111 concatenated (word 108 most significant) when word 108 bits 15:12 equal 5, and zero otherwise.
- R12: When `sigUpper` is 0xEB14, `capFlags` bit 5 (packet) is set, bit 6 (16-byte command block) equals word 0 bit 0, and sector parsing is skipped (R9 defaults). Bit 6 is never set for other devices.
- R13: Accepting word 0 starts a new block and clears every kept word, so a kept word not delivered in that block is evaluated as zero.
- R14: A word 255 that arrives while no block is open (no word 0 accepted since the last `done`) produces no `done` and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wordValid | input | 1 | A word is presented this cycle |
| wordIdx | input | 8 | Index of the presented word |
| wordData | input | 16 | Value of the presented word |
| sigUpper | input | 16 | Upper half of the device signature |
| done | output | 1 | One-cycle completion pulse |
| capFlags | output | 8 | Capability flags, bit positions as in R2, R6, R7, R12 |
| udmaCount | output | 8 | Transfer-mode level, 0xFF for none |
| speeds | output | 3 | Supported link speed bits |
| logSectSize | output | 33 | Logical sector size in bytes |
| physShift | output | 3 | Log2 of logical sectors per physical sector |
| capacity | output | 64 | Capacity in physical sectors |
| reject | output | 1 | Drive must be refused |
| wwn | output | 64 | World wide name or zero |

## Verification
Each result is a pure function of the kept words, so a corrupted capture slot or a wrong selection shows up in the very next `done` cycle as a field that differs from the value computed from the words sent. Stale storage, where the clear at word 0 is missing, only becomes visible when a block omits words that an earlier block supplied, so the bench sends such a block. A broken block-open state shows up as an extra or missing `done` pulse one cycle after a stray or genuine final word. Random blocks with biased signature fields run alongside directed cases for every selection branch.

// File: rtl/identParsePkg.sv
package identParsePkg;

  localparam int WORD_W = 16;
  localparam int IDX_W  = 8;
  localparam int NFLAG  = 8;
  localparam int SIZE_W = 33;
  localparam int CAP_W  = 64;

  localparam int F_LBA    = 0;
  localparam int F_LBA48  = 1;
  localparam int F_SMART  = 2;
  localparam int F_POWER  = 3;
  localparam int F_NOP    = 4;
  localparam int F_PACKET = 5;
  localparam int F_CDB16  = 6;
  localparam int F_ATA8   = 7;

  localparam logic [WORD_W-1:0] PACKET_SIG = 16'hEB14;

  localparam int NKEEP = 31;
  localparam logic [IDX_W-1:0] KEEP_IDX [NKEEP] = '{
    8'd0,   8'd1,   8'd3,   8'd6,   8'd49,  8'd53,  8'd54,  8'd55,
    8'd56,  8'd60,  8'd61,  8'd76,  8'd78,  8'd79,  8'd80,  8'd82,
    8'd83,  8'd86,  8'd88,  8'd100, 8'd101, 8'd102, 8'd103, 8'd106,
    8'd108, 8'd109, 8'd110, 8'd111, 8'd117, 8'd118, 8'd222
  };

  typedef struct packed {
    logic clear;
    logic capture;
    logic finish;
  } strobeT;

  function automatic logic [WORD_W-1:0] pickWord(
    input logic [NKEEP*WORD_W-1:0] flat,
    input int idx
  );
    logic [WORD_W-1:0] r;
    r = '0;
    for (int k = 0; k < NKEEP; k++)
      if (int'(KEEP_IDX[k]) == idx) r = flat[k*WORD_W +: WORD_W];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] onesToZero(input logic [WORD_W-1:0] w);
    return (w == '1) ? '0 : w;
  endfunction

endpackage

// File: rtl/identParseCtrl.sv
module identParseCtrl
  import identParsePkg::*;
#(
  parameter int LAST_IDX = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wordValid,
  input  logic [IDX_W-1:0] wordIdx,
  output strobeT           strobe,
  output logic             done
);

  logic blockOpen;
  logic isFirst;
  logic isLast;

  assign isFirst = wordValid && (wordIdx == '0);
  assign isLast  = wordValid && (wordIdx == IDX_W'(LAST_IDX));

  always_comb begin
    strobe.clear   = isFirst;
    strobe.capture = wordValid;
    strobe.finish  = isLast && (blockOpen || isFirst);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blockOpen <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.finish)     blockOpen <= 1'b0;
      else if (strobe.clear) blockOpen <= 1'b1;
    end
  end

endmodule

// File: rtl/identParseStore.sv
module identParseStore
  import identParsePkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  strobe,
  input  logic [IDX_W-1:0]        wordIdx,
  input  logic [WORD_W-1:0]       wordData,
  output logic [NKEEP*WORD_W-1:0] keptFlat
);

  for (genvar g = 0; g < NKEEP; g++) begin : gSlot
    logic hit;
    assign hit = strobe.capture && (wordIdx == KEEP_IDX[g]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             keptFlat[g*WORD_W +: WORD_W] <= '0;
      else if (hit)          keptFlat[g*WORD_W +: WORD_W] <= wordData;
      else if (strobe.clear) keptFlat[g*WORD_W +: WORD_W] <= '0;
    end
  end

endmodule

// File: rtl/identParseEval.sv
module identParseEval
  import identParsePkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  strobe,
  input  logic [NKEEP*WORD_W-1:0] keptFlat,
  input  logic [WORD_W-1:0]       sigUpper,
  output logic [NFLAG-1:0]        capFlags,
  output logic [7:0]              udmaCount,
  output logic [2:0]              speeds,
  output logic [SIZE_W-1:0]       logSectSize,
  output logic [2:0]              physShift,
  output logic [CAP_W-1:0]        capacity,
  output logic                    reject,
  output logic [63:0]             wwn
);

  logic [WORD_W-1:0] w0, w1, w3, w6, w49, w53, w54, w55, w56, w60, w61;
  logic [WORD_W-1:0] w76c, w78, w79, w80c, w82, w83, w86, w88;
  logic [WORD_W-1:0] w100, w101, w102, w103, w106;
  logic [WORD_W-1:0] w108, w109, w110, w111, w117, w118, w222c;

  always_comb begin
    w0   = pickWord(keptFlat, 0);
    w1   = pickWord(keptFlat, 1);
    w3   = pickWord(keptFlat, 3);
    w6   = pickWord(keptFlat, 6);
    w49  = pickWord(keptFlat, 49);
    w53  = pickWord(keptFlat, 53);
    w54  = pickWord(keptFlat, 54);
    w55  = pickWord(keptFlat, 55);
    w56  = pickWord(keptFlat, 56);
    w60  = pickWord(keptFlat, 60);
    w61  = pickWord(keptFlat, 61);
    w76c = onesToZero(pickWord(keptFlat, 76));
    w78  = pickWord(keptFlat, 78);
    w79  = pickWord(keptFlat, 79);
    w80c = onesToZero(pickWord(keptFlat, 80));
    w82  = pickWord(keptFlat, 82);
    w83  = pickWord(keptFlat, 83);
    w86  = pickWord(keptFlat, 86);
    w88  = pickWord(keptFlat, 88);
    w100 = pickWord(keptFlat, 100);
    w101 = pickWord(keptFlat, 101);
    w102 = pickWord(keptFlat, 102);
    w103 = pickWord(keptFlat, 103);
    w106 = pickWord(keptFlat, 106);
    w108 = pickWord(keptFlat, 108);
    w109 = pickWord(keptFlat, 109);
    w110 = pickWord(keptFlat, 110);
    w111 = pickWord(keptFlat, 111);
    w117 = pickWord(keptFlat, 117);
    w118 = pickWord(keptFlat, 118);
    w222c = onesToZero(pickWord(keptFlat, 222));
  end

  // addressing and capacity selection
  logic             isPacket, hasLba, hasLba48;
  logic [WORD_W-1:0] cyl, hd, sec;
  logic [CAP_W-1:0] chsProd, rawCap;

  always_comb begin
    isPacket = (sigUpper == PACKET_SIG);
    hasLba   = w49[9];
    hasLba48 = hasLba && (w83[10] || w86[10]);
    if (w53[0]) begin
      cyl = w1;  hd = w3;  sec = w6;
    end else begin
      cyl = w54; hd = w55; sec = w56;
    end
    chsProd = CAP_W'(cyl) * CAP_W'(hd) * CAP_W'(sec);
    if (!hasLba)        rawCap = chsProd;
    else if (hasLba48)  rawCap = {w103, w102, w101, w100};
    else                rawCap = {32'd0, w61, w60};
  end

  // transfer-mode level
  logic [7:0] udmaNext;
  logic [7:0] topBit;
  always_comb begin
    topBit = 8'd0;
    for (int b = 0; b < 7; b++)
      if (w88[b]) topBit = 8'(b + 1);
    if (w49[8] && w53[2]) udmaNext = 8'hFF + topBit;
    else                  udmaNext = 8'hFF;
  end

  // feature words gated by a valid signature
  logic w83Valid, pwrNext, smartNext, nopNext;
  always_comb begin
    w83Valid  = (w83[15:14] == 2'b01);
    pwrNext   = w83Valid && w83[3];
    smartNext = w83Valid && w82[0];
    nopNext   = w83Valid && w82[14];
  end

  // link speeds and rejection
  logic       ata8, linkInfo, rejectNext;
  logic [2:0] speedsNext;
  logic [WORD_W-1:0] keepMask;
  always_comb begin
    ata8       = w80c[8];
    linkInfo   = ata8 && (w222c[15:12] == 4'h1) && (w76c != '0);
    keepMask   = w78 & w79;
    speedsNext = linkInfo ? w76c[3:1] : 3'd0;
    rejectNext = linkInfo && !keepMask[6];
  end

  // sector geometry
  logic [31:0]       sizeWord;
  logic [SIZE_W-1:0] sizeNext;
  logic [2:0]        shiftNext;
  always_comb begin
    sizeWord  = {w118, w117};
    sizeNext  = SIZE_W'(512);
    shiftNext = 3'd0;
    if (!isPacket && (w106[15:14] == 2'b01)) begin
      if (sizeWord >= 32'd256) sizeNext = {sizeWord, 1'b0};
      if (w106[13])            shiftNext = w106[2:0];
    end
  end

  logic [63:0]       wwnNext;
  logic [NFLAG-1:0]  flagsNext;
  always_comb begin
    wwnNext = (w108[15:12] == 4'h5) ? {w108, w109, w110, w111} : 64'd0;
    flagsNext           = '0;
    flagsNext[F_LBA]    = hasLba;
    flagsNext[F_LBA48]  = hasLba48;
    flagsNext[F_SMART]  = smartNext;
    flagsNext[F_POWER]  = pwrNext;
    flagsNext[F_NOP]    = nopNext;
    flagsNext[F_PACKET] = isPacket;
    flagsNext[F_CDB16]  = isPacket && w0[0];
    flagsNext[F_ATA8]   = ata8;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capFlags    <= '0;
      udmaCount   <= '0;
      speeds      <= '0;
      logSectSize <= '0;
      physShift   <= '0;
      capacity    <= '0;
      reject      <= 1'b0;
      wwn         <= '0;
    end else if (strobe.finish) begin
      capFlags    <= flagsNext;
      udmaCount   <= udmaNext;
      speeds      <= speedsNext;
      logSectSize <= sizeNext;
      physShift   <= shiftNext;
      capacity    <= rawCap >> shiftNext;
      reject      <= rejectNext;
      wwn         <= wwnNext;
    end
  end

endmodule

// File: rtl/identParse.sv
module identParse
  import identParsePkg::*;
#(
  parameter int LAST_IDX = 255
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [WORD_W-1:0] wordData,
  input  logic [WORD_W-1:0] sigUpper,
  output logic              done,
  output logic [NFLAG-1:0]  capFlags,
  output logic [7:0]        udmaCount,
  output logic [2:0]        speeds,
  output logic [SIZE_W-1:0] logSectSize,
  output logic [2:0]        physShift,
  output logic [CAP_W-1:0]  capacity,
  output logic              reject,
  output logic [63:0]       wwn
);

  strobeT                  strobe;
  logic [NKEEP*WORD_W-1:0] keptFlat;

  identParseCtrl #(.LAST_IDX(LAST_IDX)) uCtrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIdx(wordIdx),
    .strobe(strobe), .done(done)
  );

  identParseStore uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx),
    .wordData(wordData), .keptFlat(keptFlat)
  );

  identParseEval uEval (
    .clk(clk), .rstN(rstN), .strobe(strobe), .keptFlat(keptFlat),
    .sigUpper(sigUpper), .capFlags(capFlags), .udmaCount(udmaCount),
    .speeds(speeds), .logSectSize(logSectSize), .physShift(physShift),
    .capacity(capacity), .reject(reject), .wwn(wwn)
  );

endmodule

// File: rtl/identParseChecker.sv
module identParseChecker
  import identParsePkg::*;
#(
  parameter int LAST_IDX = 255
) (
  input logic              clk,
  input logic              rstN,
  input logic              wordValid,
  input logic [IDX_W-1:0]  wordIdx,
  input logic              done,
  input logic [NFLAG-1:0]  capFlags,
  input logic [7:0]        udmaCount,
  input logic [2:0]        speeds,
  input logic [CAP_W-1:0]  capacity,
  input logic              reject,
  input logic [63:0]       wwn
);

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_last_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(wordValid && (wordIdx == IDX_W'(LAST_IDX))));

  assert_hold_outputs_R1: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(capacity) && $stable(capFlags) && $stable(wwn) && $stable(speeds)));

  assert_lba48_needs_lba_R2: assert property (@(posedge clk) disable iff (!rstN)
    capFlags[F_LBA48] |-> capFlags[F_LBA]);

  assert_udma_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && (udmaCount != 8'hFF)) |-> (udmaCount <= 8'd6));

  assert_reject_needs_ata8_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && reject) |-> capFlags[F_ATA8]);

  assert_wwn_nibble_R11: assert property (@(posedge clk) disable iff (!rstN)
    (done && (wwn != 64'd0)) |-> (wwn[63:60] == 4'h5));

  assert_cdb16_packet_R12: assert property (@(posedge clk) disable iff (!rstN)
    capFlags[F_CDB16] |-> capFlags[F_PACKET]);

endmodule

bind identParse identParseChecker #(.LAST_IDX(LAST_IDX)) uChecker (
  .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIdx(wordIdx),
  .done(done), .capFlags(capFlags), .udmaCount(udmaCount), .speeds(speeds),
  .capacity(capacity), .reject(reject), .wwn(wwn)
);

// File: tb/identParse_test.sv
module identParse_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [7:0]  wordIdx = '0;
  logic [15:0] wordData = '0;
  logic [15:0] sigUpper = '0;
  logic        done;
  logic [7:0]  capFlags;
  logic [7:0]  udmaCount;
  logic [2:0]  speeds;
  logic [32:0] logSectSize;
  logic [2:0]  physShift;
  logic [63:0] capacity;
  logic        reject;
  logic [63:0] wwn;

  int checks = 0;
  int errors = 0;

  logic [15:0] mem [256];
  bit          sendMask [256];

  logic [7:0]  eFlags, eUdma;
  logic [2:0]  eSpeeds, eShift;
  logic [32:0] eSize;
  logic [63:0] eCap, eWwn;
  logic        eReject;

  always #(CLK_PERIOD/2) clk = ~clk;

  identParse uut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIdx(wordIdx),
    .wordData(wordData), .sigUpper(sigUpper), .done(done),
    .capFlags(capFlags), .udmaCount(udmaCount), .speeds(speeds),
    .logSectSize(logSectSize), .physShift(physShift), .capacity(capacity),
    .reject(reject), .wwn(wwn)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ew(input int i);
    return sendMask[i] ? mem[i] : 16'h0000;
  endfunction

  function automatic logic [15:0] ewz(input int i);
    return (ew(i) == 16'hFFFF) ? 16'h0000 : ew(i);
  endfunction

  // expected results from the requirement text
  task automatic computeExpected();
    logic pkt, lba, lba48, w83ok, link;
    logic [63:0] raw, c, h, s;
    logic [31:0] sw;
    int n;
    pkt   = (sigUpper == 16'hEB14);
    lba   = ew(49)[9];
    lba48 = lba && (ew(83)[10] || ew(86)[10]);
    if (ew(53)[0]) begin c = 64'(ew(1));  h = 64'(ew(3));  s = 64'(ew(6));  end
    else           begin c = 64'(ew(54)); h = 64'(ew(55)); s = 64'(ew(56)); end
    if (!lba)      raw = c * h * s;
    else if (lba48) raw = {ew(103), ew(102), ew(101), ew(100)};
    else           raw = {32'd0, ew(61), ew(60)};
    eUdma = 8'hFF;
    if (ew(49)[8] && ew(53)[2]) begin
      n = 0;
      for (logic [6:0] v = ew(88)[6:0]; v != 0; v = v >> 1) n++;
      eUdma = 8'(8'hFF + n);
    end
    w83ok = (ew(83)[15:14] == 2'b01);
    eFlags = '0;
    eFlags[0] = lba;
    eFlags[1] = lba48;
    eFlags[2] = w83ok && ew(82)[0];
    eFlags[3] = w83ok && ew(83)[3];
    eFlags[4] = w83ok && ew(82)[14];
    eFlags[5] = pkt;
    eFlags[6] = pkt && ew(0)[0];
    eFlags[7] = ewz(80)[8];
    link    = eFlags[7] && (ewz(222)[15:12] == 4'h1) && (ewz(76) != 0);
    eSpeeds = link ? ewz(76)[3:1] : 3'd0;
    eReject = link && !((ew(78) & ew(79)) & 16'h0040);
    eSize  = 33'd512;
    eShift = 3'd0;
    sw = {ew(118), ew(117)};
    if (!pkt && ew(106)[15:14] == 2'b01) begin
      if (sw >= 256) eSize = 33'(sw) * 2;
      if (ew(106)[13]) eShift = ew(106)[2:0];
    end
    eCap = raw >> eShift;
    eWwn = (ew(108)[15:12] == 4'h5) ? {ew(108), ew(109), ew(110), ew(111)} : 64'd0;
  endtask

  task automatic checkOutputs(input string lbl);
    check({lbl, " R2/R6/R7/R12 flags"}, 64'(capFlags), 64'(eFlags));
    check({lbl, " R5 udma"}, 64'(udmaCount), 64'(eUdma));
    check({lbl, " R8 speeds"}, 64'(speeds), 64'(eSpeeds));
    check({lbl, " R8 reject"}, 64'(reject), 64'(eReject));
    check({lbl, " R9 size"}, 64'(logSectSize), 64'(eSize));
    check({lbl, " R9 shift"}, 64'(physShift), 64'(eShift));
    check({lbl, " R3/R4/R10 capacity"}, capacity, eCap);
    check({lbl, " R11 wwn"}, wwn, eWwn);
  endtask

  task automatic sendBlock(input string lbl, input bit gaps);
    for (int i = 0; i < 256; i++) begin
      if (!sendMask[i]) continue;
      if (gaps && ($urandom % 8 == 0)) begin
        @(negedge clk); wordValid = 1'b0;
      end
      @(negedge clk);
      wordValid = 1'b1; wordIdx = 8'(i); wordData = mem[i];
    end
    @(negedge clk);
    wordValid = 1'b0;
    computeExpected();
    check({lbl, " R1 done pulse"}, 64'(done), 64'd1);
    checkOutputs(lbl);
    @(negedge clk);
    check({lbl, " R1 done low"}, 64'(done), 64'd0);
    checkOutputs({lbl, " R1 hold"});
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) begin mem[i] = 16'h0; sendMask[i] = 1'b1; end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1D01));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset done", 64'(done), 64'd0);
    check("R1 reset capacity", capacity, 64'd0);
    check("R1 reset flags", 64'(capFlags), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 geometry from words 1,3,6
    clearMem(); mem[53] = 16'h0001; mem[1] = 16'd100; mem[3] = 16'd16; mem[6] = 16'd63;
    mem[54] = 16'd9; mem[55] = 16'd9; mem[56] = 16'd9;
    sendBlock("R4 chs-low", 1'b0);
    // R4 geometry from words 54..56
    mem[53] = 16'h0000; mem[54] = 16'd1000; mem[55] = 16'd15; mem[56] = 16'd255;
    sendBlock("R4 chs-high", 1'b0);
    // R3 plain LBA
    clearMem(); mem[49] = 16'h0200; mem[60] = 16'h5678; mem[61] = 16'h1234; mem[100] = 16'hFFFF;
    sendBlock("R3 lba28", 1'b0);
    // R3 48-bit via word 86, R6 gated off
    clearMem(); mem[49] = 16'h0200; mem[86] = 16'h0400; mem[100] = 16'h1111;
    mem[101] = 16'h2222; mem[102] = 16'h3333; mem[103] = 16'h0004;
    mem[83] = 16'h8008; mem[82] = 16'h4001;
    sendBlock("R3 lba48 R6 gated", 1'b0);
    // R6 valid signature, R5 top level
    clearMem(); mem[83] = 16'h4008; mem[82] = 16'h4001; mem[49] = 16'h0100;
    mem[53] = 16'h0004; mem[88] = 16'h007F;
    sendBlock("R6 feat R5 udma6", 1'b0);
    mem[88] = 16'hFF00;
    sendBlock("R5 udma none", 1'b0);
    // R8 rejection
    clearMem(); mem[80] = 16'h0100; mem[222] = 16'h1000; mem[76] = 16'h000E;
    mem[78] = 16'h0040; mem[79] = 16'h0000;
    sendBlock("R8 reject", 1'b0);
    mem[79] = 16'h0040;
    sendBlock("R8 accept", 1'b0);
    // R7 all-ones words read as zero
    clearMem(); mem[80] = 16'hFFFF; mem[222] = 16'hFFFF; mem[76] = 16'hFFFF;
    sendBlock("R7 ones", 1'b0);
    // R9 + R10 sector geometry
    clearMem(); mem[106] = 16'h6003; mem[117] = 16'h0800; mem[49] = 16'h0200;
    mem[60] = 16'h0000; mem[61] = 16'h0010;
    sendBlock("R9 R10 4k", 1'b0);
    mem[117] = 16'h00FF;
    sendBlock("R9 small size", 1'b0);
    // R12 packet device skips sector parsing
    sigUpper = 16'hEB14; mem[0] = 16'h0001; mem[117] = 16'h0800;
    sendBlock("R12 packet", 1'b0);
    sigUpper = 16'h0000;
    sendBlock("R12 disk cdb16 off", 1'b0);
    // R11 name
    clearMem(); mem[108] = 16'h5001; mem[109] = 16'hABCD; mem[110] = 16'h1234; mem[111] = 16'h9876;
    sendBlock("R11 wwn", 1'b0);
    mem[108] = 16'h4001;
    sendBlock("R11 wwn off", 1'b0);
    // R13: omit words 108..111 after a block that had them
    mem[108] = 16'h5001;
    sendBlock("R13 prime", 1'b0);
    for (int i = 108; i <= 111; i++) sendMask[i] = 1'b0;
    sendBlock("R13 cleared", 1'b0);
    // R14: stray final word with no open block
    @(negedge clk); wordValid = 1'b1; wordIdx = 8'd255; wordData = 16'h1234;
    @(negedge clk); wordValid = 1'b0;
    check("R14 no done", 64'(done), 64'd0);
    check("R14 wwn unchanged", wwn, 64'd0);
    @(negedge clk);
    check("R14 still no done", 64'(done), 64'd0);

    // random blocks
    for (int b = 0; b < 24; b++) begin
      clearMem();
      for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
      if ($urandom % 2) mem[83][15:14] = 2'b01;
      if ($urandom % 2) mem[106][15:14] = 2'b01;
      if ($urandom % 2) begin mem[117] = 16'($urandom % 4096); mem[118] = 16'h0; end
      if ($urandom % 2) mem[222][15:12] = 4'h1;
      if ($urandom % 2) mem[108][15:12] = 4'h5;
      if ($urandom % 2) mem[80][8] = 1'b1;
      if ($urandom % 4 == 0) mem[80] = 16'hFFFF;
      sigUpper = ($urandom % 4 == 0) ? 16'hEB14 : 16'h0101;
      sendBlock("random", 1'b1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule